// File: doc/BRIEF.md
# Paged Host Register Port for a Time-Slot Switch

This block is the host-side access port of a time-slot interchange switch. A processor reaches it through an 8-bit asynchronous strobe interface: an active-low chip select, an active-high data strobe, a read/write line, six address lines and an 8-bit data bus. The bus is split into pad-side input, output and output-enable signals. The strobe is synchronised into the switch clock domain. Each transaction is closed by an active-low acknowledge.

Only 32 channel addresses are visible at any one time. A paging control register picks which core memory is reached: connection memory low, connection memory high, or the read-only data memory. It also picks which stream. An access in the upper half of the address space then names one channel of that page.

Control register writes finish at once. Memory accesses raise a request toward the switch core and wait for a grant in the core's free access slot. Only after the grant is the acknowledge given.

Top module: `host_page_port`

## Requirements
- R1: An access begins only while chip select is low and data strobe is high at the same time. With either one inactive, no acknowledge and no core request occur.
- R2: With address bit 5 equal to 0, the access reaches the control register. All 32 such addresses alias to the same 8-bit register, and it reads back the full byte last written.
- R3: Control register bits [1:0] give the stream. Bits [4:3] give the memory: 00 connection-low, 01 connection-high, 1x data memory. The core port encodes these memories as req_mem 0, 1 and 2.
- R4: With address bit 5 equal to 1, address bits [4:0] give the channel. The request carries that channel, the paged stream, the paged memory, the direction (req_wr=1 for a write) and the write byte.
- R5: A control register write is acknowledged on the third clock edge after the strobe becomes active, which is the fastest of all transactions, and it raises no core request. A control register read also raises no request.
- R6: A memory access holds req high until gnt. The acknowledge falls on the clock edge after the grant and never earlier. Read data is the core_rdata value presented with gnt.
- R7: The acknowledge stays low until the strobe or chip select is released. Read data is driven with host_doe high while the acknowledge is low. At other times host_doe is low and the acknowledge is high.
- R8: A write to the data memory is acknowledged but raises no core request, and it leaves the memory contents unchanged.
- R9: Once acknowledged, no new request starts until the strobe is released and the port has returned to idle, however long the strobe is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Switch core clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| ds | input | 1 | Host data strobe, active high |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Host address; bit 5 selects control or channel |
| host_din | input | 8 | Data bus from the pad |
| host_dout | output | 8 | Read data toward the pad |
| host_doe | output | 1 | Pad output enable for host_dout |
| ack_n | output | 1 | Transfer acknowledge, active low |
| req | output | 1 | Core access request |
| req_wr | output | 1 | Request is a write |
| req_mem | output | 2 | Target memory: 0 conn-low, 1 conn-high, 2 data |
| req_stream | output | 2 | Target stream |
| req_chan | output | 5 | Target channel |
| req_wdata | output | 8 | Write byte |
| gnt | input | 1 | Core grant, one-cycle pulse |
| core_rdata | input | 8 | Core read data, valid with gnt |

## Verification
The bench builds the port with its default parameters: two synchroniser stages, four streams and 32 channels. Its core model therefore holds every page of all three memories, and any page/channel pair can be written and read back. The grant delay of the core model is changed between zero and ten cycles. This shows that the acknowledge follows the grant and not a fixed count. Long strobe holds and strobes with chip select inactive test the release and ignore rules.

// File: rtl/host_page_port.sv
module host_page_port #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int CHAN_W      = 5,
  parameter int STREAM_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                ds,
  input  logic                rw,
  input  logic [CHAN_W:0]     addr,
  input  logic [DATA_W-1:0]   host_din,
  output logic [DATA_W-1:0]   host_dout,
  output logic                host_doe,
  output logic                ack_n,
  output logic                req,
  output logic                req_wr,
  output logic [1:0]          req_mem,
  output logic [STREAM_W-1:0] req_stream,
  output logic [CHAN_W-1:0]   req_chan,
  output logic [DATA_W-1:0]   req_wdata,
  input  logic                gnt,
  input  logic [DATA_W-1:0]   core_rdata
);
  localparam int MSEL_LO = 3;
  localparam int MSEL_HI = 4;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_REQ, S_ACK} state_t;

  state_t              state;
  logic [SYNC_STAGES-1:0] sync;
  logic [DATA_W-1:0]   page, rbuf, wbuf;
  logic [CHAN_W-1:0]   chan;
  logic                rd;
  logic                act;

  assign act = sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[SYNC_STAGES-2:0], ~cs_n & ds};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      page  <= '0;
      rbuf  <= '0;
      wbuf  <= '0;
      chan  <= '0;
      rd    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (act) begin
          rd   <= rw;
          chan <= addr[CHAN_W-1:0];
          wbuf <= host_din;
          if (!addr[CHAN_W]) begin
            if (!rw) begin
              page  <= host_din;
              state <= S_ACK;
            end else begin
              rbuf  <= page;
              state <= S_HOLD;
            end
          end else if (!rw && page[MSEL_HI]) begin
            state <= S_HOLD;
          end else begin
            state <= S_REQ;
          end
        end
        S_HOLD: state <= S_ACK;
        S_REQ: if (gnt) begin
          if (rd) rbuf <= core_rdata;
          state <= S_ACK;
        end
        S_ACK: if (!act) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ack_n      = (state != S_ACK);
  assign host_doe   = (state == S_ACK) && rd;
  assign host_dout  = rbuf;
  assign req        = (state == S_REQ);
  assign req_wr     = ~rd;
  assign req_mem    = page[MSEL_HI] ? 2'd2 : {1'b0, page[MSEL_LO]};
  assign req_stream = page[STREAM_W-1:0];
  assign req_chan   = chan;
  assign req_wdata  = wbuf;

  a_r6_ack_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_n) && $past(req)) |-> $past(gnt));
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt) |=> req);
  a_r7_ack_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && act) |=> !ack_n);
  a_r8_no_dm_write: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !(req_wr && req_mem == 2'd2));
  a_r9_no_req_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !req);
endmodule

// File: tb/host_page_port_tb.sv
module host_page_port_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ds = 0, rw = 1;
  logic [5:0] addr = 0;
  logic [7:0] host_din = 0, host_dout, req_wdata, core_rdata;
  logic host_doe, ack_n, req, req_wr, gnt;
  logic [1:0] req_mem, req_stream;
  logic [4:0] req_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_page_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds(ds), .rw(rw), .addr(addr),
    .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe), .ack_n(ack_n),
    .req(req), .req_wr(req_wr), .req_mem(req_mem), .req_stream(req_stream),
    .req_chan(req_chan), .req_wdata(req_wdata), .gnt(gnt), .core_rdata(core_rdata));

  logic [7:0] cml [128];
  logic [7:0] cmh [128];
  logic [7:0] dmm [128];
  int gdelay = 0, gcnt = 0, ngrant = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      gnt <= 0; gcnt <= 0; core_rdata <= 0;
    end else if (gnt) begin
      gnt <= 0; gcnt <= 0;
    end else if (req) begin
      if (gcnt >= gdelay) begin
        gnt <= 1;
        ngrant <= ngrant + 1;
        case (req_mem)
          2'd0: begin core_rdata <= cml[{req_stream, req_chan}];
                      if (req_wr) cml[{req_stream, req_chan}] <= req_wdata; end
          2'd1: begin core_rdata <= cmh[{req_stream, req_chan}];
                      if (req_wr) cmh[{req_stream, req_chan}] <= req_wdata; end
          default: begin core_rdata <= dmm[{req_stream, req_chan}];
                      if (req_wr) dmm[{req_stream, req_chan}] <= req_wdata; end
        endcase
      end else gcnt <= gcnt + 1;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [7:0] exp_q[$];
  logic prev_ack = 1;
  always @(negedge clk) begin
    if (rst_n && prev_ack && !ack_n && host_doe) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected read", host_dout, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(host_dout == e, "R6 read data", host_dout, e);
      end
    end
    prev_ack = ack_n;
  end

  int lat;
  bit pg;
  logic [7:0] rd;

  task automatic access(input bit r, input logic [5:0] a, input logic [7:0] wd, input int hold);
    int n0;
    @(negedge clk);
    rw = r; addr = a; host_din = wd; cs_n = 0; ds = 1;
    lat = 0; pg = 0;
    while (ack_n && lat < 300) begin
      @(negedge clk); lat++;
      if (ack_n) pg = gnt;
    end
    rd = host_dout;
    n0 = ngrant;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(!ack_n && !req, "R9 ack held, no new request", ack_n, 0);
    end
    chk(ngrant == n0, "R9 no extra grant during hold", ngrant, n0);
    ds = 0; cs_n = 1;
    repeat (4) @(negedge clk);
    chk(ack_n && !host_doe, "R7 released", {ack_n, host_doe}, 2);
  endtask

  task automatic rd_exp(input logic [5:0] a, input logic [7:0] e);
    exp_q.push_back(e);
    access(1, a, 0, 0);
  endtask

  initial begin
    int g0;
    for (int i = 0; i < 128; i++) begin
      cml[i] = 0; cmh[i] = 0; dmm[i] = 8'(i * 5 + 3);
    end
    fork
      begin
        repeat (100000) @(negedge clk);
        chk(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk(ack_n && !req && !host_doe, "reset state", {ack_n, req, host_doe}, 4);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1: strobe with chip select inactive, and chip select without strobe
    cs_n = 1; ds = 1; rw = 0; addr = 6'h20;
    repeat (8) @(negedge clk);
    chk(ack_n && !req, "R1 cs_n high ignored", ack_n, 1);
    ds = 0; cs_n = 0;
    repeat (8) @(negedge clk);
    chk(ack_n && !req, "R1 ds low ignored", ack_n, 1);
    cs_n = 1;
    repeat (4) @(negedge clk);

    // R5 fast control write
    g0 = ngrant;
    access(0, 6'h00, 8'h02, 0);
    chk(lat == 3, "R5 control write latency", lat, 3);
    chk(ngrant == g0, "R5 no core request", ngrant, g0);
    // R2 alias read at other address
    rd_exp(6'h1F, 8'h02);
    chk(lat > 3, "R5 control read slower than write", lat, 4);
    access(0, 6'h15, 8'hE9, 0);
    rd_exp(6'h07, 8'hE9);
    chk(ngrant == g0, "R5 control read no request", ngrant, g0);

    // R3/R4: conn-low stream 2
    access(0, 6'h00, 8'h02, 0);
    gdelay = 0;
    access(0, 6'h25, 8'h5A, 0);
    chk(cml[{2'd2, 5'd5}] == 8'h5A, "R4 conn-low write stream2 ch5", cml[{2'd2, 5'd5}], 8'h5A);
    chk(pg, "R6 ack after grant", pg, 1);
    // R3 conn-high stream 1 with long grant delay
    access(0, 6'h00, 8'h09, 0);
    gdelay = 10;
    access(0, 6'h3F, 8'hC3, 0);
    chk(cmh[{2'd1, 5'd31}] == 8'hC3, "R3 conn-high write stream1 ch31", cmh[{2'd1, 5'd31}], 8'hC3);
    chk(lat >= 13 && pg, "R6 ack waits for slow grant", lat, 14);
    chk(cml[{2'd1, 5'd31}] == 8'h00, "R3 conn-low untouched", cml[{2'd1, 5'd31}], 0);
    rd_exp(6'h3F, 8'hC3);
    chk(pg, "R6 read ack after grant", pg, 1);
    // back to conn-low stream 2 read
    gdelay = 3;
    access(0, 6'h00, 8'h02, 0);
    rd_exp(6'h25, 8'h5A);
    // R3 data memory via bit 4 (1x), stream 3
    access(0, 6'h00, 8'h1B, 0);
    rd_exp(6'h20, dmm[{2'd3, 5'd0}]);
    rd_exp(6'h2C, dmm[{2'd3, 5'd12}]);
    // R8 data memory write ignored
    g0 = ngrant;
    access(0, 6'h2C, 8'hFF, 0);
    chk(ngrant == g0, "R8 dm write no request", ngrant, g0);
    chk(lat < 300, "R8 dm write acknowledged", lat, 4);
    rd_exp(6'h2C, 8'(12 * 5 + 3 + 3 * 32 * 5));
    // R9 long hold after memory read
    access(0, 6'h00, 8'h00, 0);
    exp_q.push_back(8'h00);
    access(1, 6'h25, 0, 12);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all reads observed", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule